// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that software controls only by writing 16-bit magic words into a key register. A low-speed tick strobe, which the surrounding chip supplies in the bus clock domain, feeds a power-of-two prescaler. Each prescaled period steps a 12-bit down-counter. Once started, the counter cannot be stopped by software. If nobody refreshes it in time, the block issues a one-cycle reset pulse and then returns to its power-on state.

The prescaler code, the reload value and a stored window placeholder are protected against stray writes. They can be changed only after an unlock word has been written to the key register. An accepted prescaler or reload write does not reach the counter at once. The hand-over is modelled as a fixed number of tick periods. During that time a busy flag in the status register stays set. The counter keeps using the old value until the flag clears.

Top module: `wdg_keyed`

## Requirements
- R1: After reset the block is idle and reads back as follows: prescaler code 0, reload 0xFFF, window 0xFFF, status 0, key register 0. `wdg_rst` is low.
- R2: Writing 0xCCCC to the key register (offset 0x00, all 16 bits compared) starts counting. Once the block is running, no key write stops it.
- R3: With active prescaler code c and active reload r, `wdg_rst` rises on the (r+1)*(4<<c)-th tick counted from the start or the last refresh.
- R4: Writing 0xAAAA to the key register while running reloads the counter from the active reload value and restarts the prescaled period.
- R5: Writing 0x5555 to the key register unlocks configuration writes. Any other key write, including 0x0000, 0xAAAA and 0xCCCC, locks them again.
- R6: While locked, writes to the prescaler (0x04), reload (0x08) and window (0x10) registers leave the stored values unchanged.
- R7: The prescaler code is bits 3:0 at 0x04. A code above the largest one (PRESC_MAX_LOG2-2, which is 6 by default, dividing by 256) is stored as that largest code. Reload and window are bits 11:0. Reload 0 gives a period of one prescaled step.
- R8: Status at 0x0C has bit 0 set while a prescaler update is pending and bit 1 set while a reload update is pending. Upper bits read 0. A flag rises on the accepted write and clears on the SYNC_TICKS-th tick after it. Until then the counter uses the previous value.
- R9: `wdg_rst` is high for exactly one clock cycle. Afterwards the block is idle, locked, not busy, and holds prescaler code 0 and reload 0xFFF.
- R10: A key word other than the four defined ones neither starts nor refreshes the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tick | input | 1 | Low-speed tick strobe, one clock cycle wide |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| wdg_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The assertions assume that bus writes are single-cycle strobes sampled at the clock edge, and that `tick` is a one-cycle strobe synchronous to `clk`. The bench generates `tick` from the clock as one pulse every three cycles. It drives the bus only at falling edges, so every write, tick and refresh lands on a well-defined rising edge. The bench never starts the watchdog while it is already running, because the block ignores a restart then. Its tick counting is valid only as long as that rule holds.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam logic [4:0] OFS_KEY    = 5'h00;
  localparam logic [4:0] OFS_PRESC  = 5'h04;
  localparam logic [4:0] OFS_RELOAD = 5'h08;
  localparam logic [4:0] OFS_STATUS = 5'h0C;
  localparam logic [4:0] OFS_WINDOW = 5'h10;

  localparam logic [15:0] KEY_START   = 16'hCCCC;
  localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [15:0] KEY_OPEN    = 16'h5555;
  localparam logic [15:0] KEY_CLOSE   = 16'h0000;

  typedef enum logic [2:0] {
    KC_NONE,
    KC_START,
    KC_REFRESH,
    KC_OPEN,
    KC_CLOSE,
    KC_OTHER
  } key_cmd_e;

  // Map a written key word to its command.
  function automatic key_cmd_e decode_key(input logic [15:0] k);
    case (k)
      KEY_START:   return KC_START;
      KEY_REFRESH: return KC_REFRESH;
      KEY_OPEN:    return KC_OPEN;
      KEY_CLOSE:   return KC_CLOSE;
      default:     return KC_OTHER;
    endcase
  endfunction

  // Saturate a requested prescaler code to the largest legal one.
  function automatic logic [3:0] clamp_code(input logic [3:0] v,
                                            input logic [3:0] max_code);
    return (v > max_code) ? max_code : v;
  endfunction

  // Last count value of the prescaler for a code: divide by 4 << code.
  function automatic logic [15:0] presc_last(input logic [3:0] code);
    return (16'd4 << code) - 16'd1;
  endfunction

endpackage

// File: rtl/wdg_key_decode.sv
module wdg_key_decode
  import wdg_pkg::*;
(
  input  logic        wr_key,
  input  logic [15:0] key_word,
  output logic        key_start,
  output logic        key_refresh,
  output logic        key_open,
  output logic        key_lock
);

  key_cmd_e cmd;

  always_comb begin
    cmd = wr_key ? decode_key(key_word) : KC_NONE;
    key_start   = (cmd == KC_START);
    key_refresh = (cmd == KC_REFRESH);
    key_open    = (cmd == KC_OPEN);
    // every key write that is not the open word closes access
    key_lock    = wr_key && (cmd != KC_OPEN);
  end

endmodule

// File: rtl/wdg_cfg_gate.sv
module wdg_cfg_gate
  import wdg_pkg::*;
#(
  parameter int RELOAD_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                key_open,
  input  logic                key_lock,
  input  logic                bus_we,
  input  logic [4:0]          bus_addr,
  input  logic [RELOAD_W-1:0] wr_field,
  output logic                unlocked,
  output logic                presc_wr,
  output logic                reload_wr,
  output logic [RELOAD_W-1:0] window_q
);

  localparam logic [RELOAD_W-1:0] WIN_INIT = {RELOAD_W{1'b1}};

  logic window_wr;

  always_comb begin
    presc_wr  = unlocked && bus_we && (bus_addr == OFS_PRESC);
    reload_wr = unlocked && bus_we && (bus_addr == OFS_RELOAD);
    window_wr = unlocked && bus_we && (bus_addr == OFS_WINDOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      window_q <= WIN_INIT;
    end else if (clear) begin
      unlocked <= 1'b0;
      window_q <= WIN_INIT;
    end else begin
      if (key_open)      unlocked <= 1'b1;
      else if (key_lock) unlocked <= 1'b0;
      if (window_wr)     window_q <= wr_field;
    end
  end

endmodule

// File: rtl/wdg_update_sync.sv
module wdg_update_sync #(
  parameter int          W          = 12,
  parameter int          SYNC_TICKS = 3,
  parameter logic [W-1:0] INIT      = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] active_q,
  output logic         busy_q
);

  localparam int SC_W = $clog2(SYNC_TICKS + 1);
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(SYNC_TICKS - 1);

  logic [SC_W-1:0] sc_q;
  logic            hand_over;

  assign hand_over = busy_q && tick && (sc_q == SC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= INIT;
      active_q <= INIT;
      busy_q   <= 1'b0;
      sc_q     <= '0;
    end else if (clear) begin
      pend_q   <= INIT;
      active_q <= INIT;
      busy_q   <= 1'b0;
      sc_q     <= '0;
    end else if (load) begin
      pend_q <= load_val;
      busy_q <= 1'b1;
      sc_q   <= '0;
    end else if (hand_over) begin
      active_q <= pend_q;
      busy_q   <= 1'b0;
      sc_q     <= '0;
    end else if (busy_q && tick) begin
      sc_q <= sc_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdg_down_counter.sv
module wdg_down_counter
  import wdg_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int RELOAD_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                tick,
  input  logic                key_start,
  input  logic                key_refresh,
  input  logic [3:0]          code,
  input  logic [RELOAD_W-1:0] reload,
  output logic                running,
  output logic                step_evt,
  output logic                fire_evt
);

  logic [DIV_W-1:0]    div_q;
  logic [RELOAD_W-1:0] cnt_q;
  logic [DIV_W-1:0]    div_last;
  logic                do_load;
  logic                div_wrap;

  assign div_last = DIV_W'(presc_last(code));
  assign do_load  = (key_start && !running) || (key_refresh && running);
  assign div_wrap = running && tick && !do_load && (div_q == div_last);
  assign step_evt = div_wrap && (cnt_q != '0);
  assign fire_evt = div_wrap && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      div_q   <= '0;
      cnt_q   <= '0;
    end else if (clear) begin
      running <= 1'b0;
      div_q   <= '0;
      cnt_q   <= '0;
    end else if (do_load) begin
      running <= 1'b1;
      div_q   <= '0;
      cnt_q   <= reload;
    end else if (running && tick) begin
      if (div_wrap) begin
        div_q <= '0;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdg_keyed.sv
module wdg_keyed
  import wdg_pkg::*;
#(
  parameter int PRESC_MAX_LOG2 = 8,
  parameter int SYNC_TICKS     = 3,
  parameter int RELOAD_W       = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        wdg_rst
);

  localparam logic [3:0]          MAX_CODE    = 4'(PRESC_MAX_LOG2 - 2);
  localparam int                  DIV_W       = PRESC_MAX_LOG2;
  localparam logic [RELOAD_W-1:0] RELOAD_INIT = {RELOAD_W{1'b1}};

  logic                key_start, key_refresh, key_open, key_lock;
  logic                unlocked, presc_wr, reload_wr;
  logic [RELOAD_W-1:0] window_q;
  logic [3:0]          presc_pend, presc_act;
  logic [RELOAD_W-1:0] reload_pend, reload_act;
  logic                busy_presc, busy_reload;
  logic                running, step_evt, fire_evt;
  logic [3:0]          code_in;

  assign code_in = clamp_code(bus_wdata[3:0], MAX_CODE);

  wdg_key_decode u_key (
    .wr_key      (bus_we && (bus_addr == OFS_KEY)),
    .key_word    (bus_wdata),
    .key_start   (key_start),
    .key_refresh (key_refresh),
    .key_open    (key_open),
    .key_lock    (key_lock)
  );

  wdg_cfg_gate #(.RELOAD_W(RELOAD_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (fire_evt),
    .key_open  (key_open),
    .key_lock  (key_lock),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .wr_field  (bus_wdata[RELOAD_W-1:0]),
    .unlocked  (unlocked),
    .presc_wr  (presc_wr),
    .reload_wr (reload_wr),
    .window_q  (window_q)
  );

  wdg_update_sync #(.W(4), .SYNC_TICKS(SYNC_TICKS), .INIT(4'd0)) u_sync_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (fire_evt),
    .tick     (tick),
    .load     (presc_wr),
    .load_val (code_in),
    .pend_q   (presc_pend),
    .active_q (presc_act),
    .busy_q   (busy_presc)
  );

  wdg_update_sync #(.W(RELOAD_W), .SYNC_TICKS(SYNC_TICKS), .INIT(RELOAD_INIT)) u_sync_reload (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (fire_evt),
    .tick     (tick),
    .load     (reload_wr),
    .load_val (bus_wdata[RELOAD_W-1:0]),
    .pend_q   (reload_pend),
    .active_q (reload_act),
    .busy_q   (busy_reload)
  );

  wdg_down_counter #(.DIV_W(DIV_W), .RELOAD_W(RELOAD_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (fire_evt),
    .tick        (tick),
    .key_start   (key_start),
    .key_refresh (key_refresh),
    .code        (presc_act),
    .reload      (reload_act),
    .running     (running),
    .step_evt    (step_evt),
    .fire_evt    (fire_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdg_rst <= 1'b0;
    else        wdg_rst <= fire_evt;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_PRESC:  bus_rdata = 16'(presc_pend);
      OFS_RELOAD: bus_rdata = 16'(reload_pend);
      OFS_STATUS: bus_rdata = {14'd0, busy_reload, busy_presc};
      OFS_WINDOW: bus_rdata = 16'(window_q);
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdg_keyed_chk.sv
module wdg_keyed_chk
  import wdg_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [4:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        wdg_rst,
  input logic        fire_evt,
  input logic        step_evt,
  input logic        running,
  input logic        unlocked,
  input logic [3:0]  presc_pend,
  input logic [11:0] reload_pend,
  input logic        busy_presc,
  input logic        busy_reload
);

  logic key_wr;
  assign key_wr = bus_we && (bus_addr == OFS_KEY);

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst |=> !wdg_rst); // R9

  AST_FIRE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    fire_evt |=> (!running && !unlocked && presc_pend == 4'd0 &&
                  reload_pend == 12'hFFF && !busy_presc && !busy_reload)); // R9

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !fire_evt) |=> running); // R2

  AST_FIRE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_evt || step_evt) |-> running); // R3

  AST_LOCKED_PRESC: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_we && bus_addr == OFS_PRESC && !fire_evt) |=> $stable(presc_pend)); // R6

  AST_LOCKED_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_we && bus_addr == OFS_RELOAD && !fire_evt) |=> $stable(reload_pend)); // R6

  AST_OPEN_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && bus_wdata == KEY_OPEN && !fire_evt) |=> unlocked); // R5

  AST_OTHER_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && bus_wdata != KEY_OPEN) |=> !unlocked); // R5

  AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && bus_we && bus_addr == OFS_RELOAD && !fire_evt) |=> busy_reload); // R8

endmodule

bind wdg_keyed wdg_keyed_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .wdg_rst     (wdg_rst),
  .fire_evt    (fire_evt),
  .step_evt    (step_evt),
  .running     (running),
  .unlocked    (unlocked),
  .presc_pend  (presc_pend),
  .reload_pend (reload_pend),
  .busy_presc  (busy_presc),
  .busy_reload (busy_reload)
);

// File: tb/wdg_keyed_tb_top.sv
module wdg_keyed_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 3;
  localparam int LIMIT      = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = 5'h00;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic        wdg_rst;

  int checks = 0;
  int fails  = 0;
  int run_ticks, upd_ticks, pulses;
  int ph;
  int exp_q[$];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdg_keyed #(.PRESC_MAX_LOG2(8), .SYNC_TICKS(SYNC), .RELOAD_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdg_rst(wdg_rst)
  );

  // tick strobe: one cycle in three
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin ph <= 0; tick <= 1'b0; end
    else begin ph <= (ph == 2) ? 0 : ph + 1; tick <= (ph == 0); end
  end

  // bench-side tick counters, cleared by the bench's own start/refresh and config writes
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin run_ticks <= 0; upd_ticks <= 0; end
    else begin
      if (bus_we && bus_addr == 5'h00 && (bus_wdata == 16'hCCCC || bus_wdata == 16'hAAAA))
        run_ticks <= 0;
      else if (tick) run_ticks <= run_ticks + 1;
      if (bus_we && (bus_addr == 5'h04 || bus_addr == 5'h08)) upd_ticks <= 0;
      else if (tick) upd_ticks <= upd_ticks + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: every reset pulse is matched against the scoreboard
  always @(negedge clk) begin
    if (rst_n && wdg_rst) begin
      pulses++;
      if (exp_q.size() == 0) chk("R10 unexpected pulse", 1, 0);
      else chk("R3 ticks to reset", run_ticks, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic wait_idle_status();
    int v;
    for (int g = 0; g < 100; g++) begin
      rd(5'h0C, v);
      if (v == 0) return;
      @(negedge clk);
    end
    chk("R8 busy never cleared", 1, 0);
  endtask

  task automatic set_cfg(input int code, input int rel);
    wr(5'h00, 16'h5555);
    wr(5'h04, 16'(code));
    wait_idle_status();
    wr(5'h08, 16'(rel));
    wait_idle_status();
    wr(5'h00, 16'h0000);
  endtask

  task automatic wait_pulse();
    int g = 0;
    while (exp_q.size() != 0 && g < 120000) begin @(negedge clk); g++; end
    if (exp_q.size() != 0) begin chk("R3 pulse missing", 0, 1); exp_q.delete(); end
  endtask

  task automatic wait_run(input int n);
    while (run_ticks < n) @(negedge clk);
  endtask

  task automatic wait_upd(input int n);
    while (upd_ticks < n) @(negedge clk);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    int p0;
    pulses = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(5'h00, v); chk("R1 key reads zero", v, 0);
    rd(5'h04, v); chk("R1 prescaler", v, 0);
    rd(5'h08, v); chk("R1 reload", v, 'hFFF);
    rd(5'h0C, v); chk("R1 status", v, 0);
    rd(5'h10, v); chk("R1 window", v, 'hFFF);
    chk("R1 reset output low", int'(wdg_rst), 0);

    // R6 locked writes ignored
    wr(5'h04, 16'h0003); rd(5'h04, v); chk("R6 locked prescaler", v, 0);
    wr(5'h08, 16'h0005); rd(5'h08, v); chk("R6 locked reload", v, 'hFFF);
    wr(5'h10, 16'h0123); rd(5'h10, v); chk("R6 locked window", v, 'hFFF);

    // R5 unlock, R7 clamp, R8 busy window
    wr(5'h00, 16'h5555);
    wr(5'h04, 16'h000F);
    rd(5'h04, v); chk("R7 code clamped to max", v, 6);
    rd(5'h0C, v); chk("R8 prescaler busy set", v, 1);
    wait_upd(SYNC - 1); rd(5'h0C, v); chk("R8 still busy before last tick", v, 1);
    wait_upd(SYNC);     rd(5'h0C, v); chk("R8 busy cleared", v, 0);
    wr(5'h08, 16'h0007);
    rd(5'h0C, v); chk("R8 reload busy bit 1", v, 2);
    wait_idle_status();
    wr(5'h10, 16'h0ABC); rd(5'h10, v); chk("R5 window accepted when unlocked", v, 'hABC);

    // R5 relock by refresh word, R10 unknown word relocks without effect
    wr(5'h00, 16'hAAAA);
    wr(5'h08, 16'h0009); rd(5'h08, v); chk("R5 refresh word relocks", v, 7);
    wr(5'h00, 16'h5555);
    wr(5'h00, 16'h1234);
    wr(5'h04, 16'h0002); rd(5'h04, v); chk("R10 odd word relocks", v, 6);
    p0 = pulses;
    repeat (60) @(negedge clk);
    chk("R10 odd word does not start", pulses, p0);

    // R3 basic timeout: code 0, reload 2 -> 12 ticks; R9 restore
    set_cfg(0, 2);
    exp_q.push_back(12);
    wr(5'h00, 16'hCCCC);
    wait_pulse();
    @(negedge clk);
    chk("R9 pulse is one cycle", int'(wdg_rst), 0);
    rd(5'h04, v); chk("R9 prescaler restored", v, 0);
    rd(5'h08, v); chk("R9 reload restored", v, 'hFFF);
    rd(5'h10, v); chk("R9 window restored", v, 'hFFF);

    // R2 cannot stop: code 1, reload 3 -> 32 ticks
    set_cfg(1, 3);
    exp_q.push_back(32);
    wr(5'h00, 16'hCCCC);
    wr(5'h00, 16'h0000);
    wr(5'h00, 16'h1234);
    wait_pulse();

    // R4 refresh restarts: code 0, reload 4 -> 20 ticks after the refresh
    set_cfg(0, 4);
    exp_q.push_back(20);
    wr(5'h00, 16'hCCCC);
    wait_run(15);
    wr(5'h00, 16'hAAAA);
    wait_pulse();

    // R7 reload 0 boundary: code 2 -> 16 ticks
    set_cfg(2, 0);
    exp_q.push_back(16);
    wr(5'h00, 16'hCCCC);
    wait_pulse();

    // R7 largest code: divide by 256, reload 0
    set_cfg(6, 0);
    exp_q.push_back(256);
    wr(5'h00, 16'hCCCC);
    wait_pulse();

    // R8 pending value not yet used: active reload 1, write 9, start at once -> 8 ticks
    set_cfg(0, 1);
    wr(5'h00, 16'h5555);
    wr(5'h08, 16'h0009);
    exp_q.push_back(8);
    wr(5'h00, 16'hCCCC);
    wait_pulse();

    // R3 power-on period: code 0, reload 0xFFF -> 16384 ticks
    @(negedge clk);
    exp_q.push_back(16384);
    wr(5'h00, 16'hCCCC);
    wait_pulse();

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule